// File: doc/BRIEF.md
# Inverted write-once coder for phase-change memory words

This block sits between a memory controller and a phase-change memory word. It turns a word of 2-bit data symbols into cell patterns, 3 cells per symbol. Programming a cell to 1 (SET) is slow, about eight read times. Clearing a cell to 0 (RESET) takes about one read time. The code is inverted so that writing only clears cells. A pre-SET request drives every cell of the word to 1 ahead of time. After it, two writes in a row go through with RESET pulses alone: the first uses a code of weight 2 or 3, and the second uses a code of weight 0 or 1.

Each 3-cell group keeps its own generation state: erased, first-written or second-written. For every operation the block reports the SET and RESET pulses it needs per cell and a latency estimate for the word. The read path decodes the stored cells back into symbols from the weight of each group alone. When a group is already second-written, a third write follows a policy chosen by an input. Either the first-generation code is written at once with whatever SETs it needs, or the group is pre-SET and then cleared to the first-generation code.

Top module: `wom_pcm_coder`

## Requirements
- R1: After reset every cell is 1, every group is erased, and `rd_data`, `set_mask`, `reset_mask`, `op_valid` and `lat` are all 0.
- R2: A pre-SET request sampled at a clock edge makes every cell 1 after that edge. At the same edge `set_mask` equals the cells that were 0, `reset_mask` is 0, `op_valid` is 1 and `lat` is `LAT_SET`. Every group becomes erased. A write request in the same cycle is dropped.
- R3: A write to an erased group stores the first code: symbol 00 as 111, 01 as 110, 10 as 101, 11 as 011. It needs no SET, and the RESET mask is the cleared cells. Symbol i sits at `wr_data[2i+1:2i]`. Its group is `cells[3i+2:3i]`, and the leftmost codeword bit is at `3i+2`.
- R4: A write of a different symbol to a first-written group stores the second code: 00 as 000, 01 as 001, 10 as 010, 11 as 100. It needs no SET, and the group becomes second-written.
- R5: A write of the symbol a first-written group already holds leaves that group's cells unchanged and its masks 0. The group stays first-written.
- R6: With `third_pre`=0, a write to a second-written group stores the first code directly. SET mask = new & ~old and RESET mask = old & ~new.
- R7: With `third_pre`=1, a write to a second-written group stores the first code. Its SET mask is every cell that was 0, and its RESET mask is every cell that is 0 in the new code.
- R8: After a third write the group counts as first-written, so a following write of a different symbol uses the second code.
- R9: `rd_data` decodes each group by weight: weight 2 or more through the first table, weight 1 or less through the second. It returns the last symbol written to the group, or 00 after a pre-SET. It is valid from the edge that stored the cells.
- R10: In the cycle after any request `op_valid` is 1. `lat` is `LAT_SET` if the operation is a pre-SET or any SET bit is set, and `LAT_RESET` otherwise. Without an operation, `op_valid`, `lat` and both masks are 0.
- R11: Groups keep their generations independently, so one write can mix first writes, second writes, unchanged groups and third writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| preset_req | input | 1 | Pre-SET the whole word to ones |
| wr_req | input | 1 | Write the word in `wr_data` |
| wr_data | input | 2*NSYM | Data symbols, symbol i at bits 2i+1:2i |
| third_pre | input | 1 | Third-write policy: 0 direct, 1 pre-SET first |
| rd_data | output | 2*NSYM | Decoded stored symbols |
| cells | output | 3*NSYM | Stored cell states |
| set_mask | output | 3*NSYM | Cells receiving a SET pulse in the last operation |
| reset_mask | output | 3*NSYM | Cells receiving a RESET pulse in the last operation |
| op_valid | output | 1 | An operation completed at the last edge |
| lat | output | LAT_W | Latency estimate of that operation |

## Verification
The bench drives writes whose per-group symbols sometimes repeat and sometimes differ, so it catches a design that advances the generation on a repeated symbol, which would force needless SETs one write later. It steps groups through a third write under both policies. A coder that mixes up the two policies shows the wrong SET mask or wrong cells. A mapping error in either table shows up as a wrong readback. A simultaneous pre-SET and write catches a design that lets the write through. Mixed generations across groups catch state shared between groups. A long random run compares every output with a behavioural model on every cycle.

// File: rtl/wom_pkg.sv
package wom_pkg;

   typedef enum logic [1:0] {
      GEN_ERASED = 2'd0,
      GEN_FIRST  = 2'd1,
      GEN_SECOND = 2'd2
   } gen_e;

   function automatic logic [2:0] enc_first(input logic [1:0] s);
      case (s)
         2'd0:    return 3'b111;
         2'd1:    return 3'b110;
         2'd2:    return 3'b101;
         default: return 3'b011;
      endcase
   endfunction

   function automatic logic [2:0] enc_second(input logic [1:0] s);
      case (s)
         2'd0:    return 3'b000;
         2'd1:    return 3'b001;
         2'd2:    return 3'b010;
         default: return 3'b100;
      endcase
   endfunction

   function automatic logic [1:0] weight3(input logic [2:0] c);
      return 2'(c[0]) + 2'(c[1]) + 2'(c[2]);
   endfunction

   function automatic logic [1:0] dec_group(input logic [2:0] c);
      logic [1:0] s;
      if (weight3(c) >= 2'd2) begin
         case (c)
            3'b110:  s = 2'd1;
            3'b101:  s = 2'd2;
            3'b011:  s = 2'd3;
            default: s = 2'd0;
         endcase
      end else begin
         case (c)
            3'b001:  s = 2'd1;
            3'b010:  s = 2'd2;
            3'b100:  s = 2'd3;
            default: s = 2'd0;
         endcase
      end
      return s;
   endfunction

endpackage

// File: rtl/wom_group.sv
module wom_group
   import wom_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       do_pre,
   input  logic       do_wr,
   input  logic [1:0] sym,
   input  logic       third_pre,
   output logic [2:0] cells,
   output logic [2:0] set_m,
   output logic [2:0] rst_m,
   output logic [1:0] rd_sym
);

   gen_e       gen_q, gen_d;
   logic [2:0] cells_d, set_d, rst_d, tgt;

   assign rd_sym = dec_group(cells);

   always_comb begin
      cells_d = cells;
      gen_d   = gen_q;
      set_d   = '0;
      rst_d   = '0;
      tgt     = enc_first(sym);
      if (do_pre) begin
         cells_d = 3'b111;
         gen_d   = GEN_ERASED;
         set_d   = ~cells;
      end else if (do_wr) begin
         case (gen_q)
            GEN_FIRST: begin
               if (rd_sym != sym) begin
                  tgt     = enc_second(sym);
                  cells_d = tgt;
                  set_d   = tgt & ~cells;
                  rst_d   = cells & ~tgt;
                  gen_d   = GEN_SECOND;
               end
            end
            GEN_SECOND: begin
               cells_d = tgt;
               gen_d   = GEN_FIRST;
               if (third_pre) begin
                  set_d = ~cells;
                  rst_d = ~tgt;
               end else begin
                  set_d = tgt & ~cells;
                  rst_d = cells & ~tgt;
               end
            end
            default: begin
               cells_d = tgt;
               set_d   = tgt & ~cells;
               rst_d   = cells & ~tgt;
               gen_d   = GEN_FIRST;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cells <= 3'b111;
         gen_q <= GEN_ERASED;
         set_m <= '0;
         rst_m <= '0;
      end else begin
         cells <= cells_d;
         gen_q <= gen_d;
         set_m <= set_d;
         rst_m <= rst_d;
      end
   end

endmodule

// File: rtl/wom_lat_merge.sv
module wom_lat_merge #(
   parameter int NCELL     = 24,
   parameter int LAT_W     = 4,
   parameter int LAT_SET   = 8,
   parameter int LAT_RESET = 1
) (
   input  logic             op_valid,
   input  logic             op_pre,
   input  logic [NCELL-1:0] set_mask,
   output logic [LAT_W-1:0] lat
);

   localparam logic [LAT_W-1:0] L_SLOW = LAT_W'(LAT_SET);
   localparam logic [LAT_W-1:0] L_FAST = LAT_W'(LAT_RESET);

   always_comb begin
      if (!op_valid)                lat = '0;
      else if (op_pre || |set_mask) lat = L_SLOW;
      else                          lat = L_FAST;
   end

endmodule

// File: rtl/wom_pcm_coder.sv
module wom_pcm_coder #(
   parameter int NSYM      = 8,
   parameter int LAT_W     = 4,
   parameter int LAT_SET   = 8,
   parameter int LAT_RESET = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                preset_req,
   input  logic                wr_req,
   input  logic [2*NSYM-1:0]   wr_data,
   input  logic                third_pre,
   output logic [2*NSYM-1:0]   rd_data,
   output logic [3*NSYM-1:0]   cells,
   output logic [3*NSYM-1:0]   set_mask,
   output logic [3*NSYM-1:0]   reset_mask,
   output logic                op_valid,
   output logic [LAT_W-1:0]    lat
);

   localparam int NCELL = 3 * NSYM;

   if (NSYM < 1) begin : g_bad_nsym
      $error("wom_pcm_coder: NSYM must be at least 1");
   end
   if (LAT_SET <= LAT_RESET || LAT_RESET < 1) begin : g_bad_lat
      $error("wom_pcm_coder: need LAT_SET > LAT_RESET >= 1");
   end
   if (LAT_SET >= (1 << LAT_W)) begin : g_bad_latw
      $error("wom_pcm_coder: LAT_W too narrow for LAT_SET");
   end

   logic do_pre, do_wr, op_pre_q;

   assign do_pre = preset_req;
   assign do_wr  = wr_req & ~preset_req;

   for (genvar g = 0; g < NSYM; g++) begin : g_grp
      wom_group u_grp (
         .clk       (clk),
         .rst_n     (rst_n),
         .do_pre    (do_pre),
         .do_wr     (do_wr),
         .sym       (wr_data[2*g +: 2]),
         .third_pre (third_pre),
         .cells     (cells[3*g +: 3]),
         .set_m     (set_mask[3*g +: 3]),
         .rst_m     (reset_mask[3*g +: 3]),
         .rd_sym    (rd_data[2*g +: 2])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_valid <= 1'b0;
         op_pre_q <= 1'b0;
      end else begin
         op_valid <= do_pre | do_wr;
         op_pre_q <= do_pre;
      end
   end

   wom_lat_merge #(
      .NCELL     (NCELL),
      .LAT_W     (LAT_W),
      .LAT_SET   (LAT_SET),
      .LAT_RESET (LAT_RESET)
   ) u_lat (
      .op_valid (op_valid),
      .op_pre   (op_pre_q),
      .set_mask (set_mask),
      .lat      (lat)
   );

endmodule

// File: rtl/wom_pcm_coder_chk.sv
module wom_pcm_coder_chk #(
   parameter int NSYM      = 8,
   parameter int LAT_W     = 4,
   parameter int LAT_SET   = 8,
   parameter int LAT_RESET = 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                preset_req,
   input logic                wr_req,
   input logic [2*NSYM-1:0]   wr_data,
   input logic [2*NSYM-1:0]   rd_data,
   input logic [3*NSYM-1:0]   cells,
   input logic [3*NSYM-1:0]   set_mask,
   input logic [3*NSYM-1:0]   reset_mask,
   input logic                op_valid,
   input logic [LAT_W-1:0]    lat
);

   // R2: a pre-SET leaves every cell at 1 and reports an operation
   a_r2_preset_ones: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(preset_req)) |-> (&cells && op_valid));

   // R3/R4/R6/R7: no cell rises unless a SET pulse covers it
   a_r7_rise_needs_set: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((cells & ~$past(cells) & ~set_mask) == '0));

   // R3/R4: no cell falls unless a RESET pulse covers it
   a_r4_fall_needs_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((~cells & $past(cells) & ~reset_mask) == '0));

   // R9: a write is read back from the edge that stored it
   a_r9_readback: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wr_req) && !$past(preset_req)) |-> (rd_data == $past(wr_data)));

   // R10: any SET pulse makes the slow latency
   a_r10_slow_lat: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (|set_mask)) |-> (lat == LAT_W'(LAT_SET)));

   // R10: idle cycles report nothing
   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |-> (lat == '0 && set_mask == '0 && reset_mask == '0));

endmodule

bind wom_pcm_coder wom_pcm_coder_chk #(
   .NSYM      (NSYM),
   .LAT_W     (LAT_W),
   .LAT_SET   (LAT_SET),
   .LAT_RESET (LAT_RESET)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .preset_req (preset_req),
   .wr_req     (wr_req),
   .wr_data    (wr_data),
   .rd_data    (rd_data),
   .cells      (cells),
   .set_mask   (set_mask),
   .reset_mask (reset_mask),
   .op_valid   (op_valid),
   .lat        (lat)
);

// File: tb/wom_pcm_coder_tb.sv
module wom_pcm_coder_tb;

   localparam int NSYM      = 8;
   localparam int LAT_W     = 4;
   localparam int LAT_SET   = 8;
   localparam int LAT_RESET = 1;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                preset_req = 1'b0;
   logic                wr_req = 1'b0;
   logic [2*NSYM-1:0]   wr_data = '0;
   logic                third_pre = 1'b0;
   logic [2*NSYM-1:0]   rd_data;
   logic [3*NSYM-1:0]   cells, set_mask, reset_mask;
   logic                op_valid;
   logic [LAT_W-1:0]    lat;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int m_cells [NSYM];
   int m_gen   [NSYM];
   int m_sym   [NSYM];
   logic [3*NSYM-1:0] e_cells, e_set, e_rst;
   logic [2*NSYM-1:0] e_rd;
   logic              e_opv;
   logic [LAT_W-1:0]  e_lat;

   always #2.5 clk = ~clk;

   wom_pcm_coder #(.NSYM(NSYM), .LAT_W(LAT_W), .LAT_SET(LAT_SET), .LAT_RESET(LAT_RESET)) u_dut (
      .clk(clk), .rst_n(rst_n), .preset_req(preset_req), .wr_req(wr_req),
      .wr_data(wr_data), .third_pre(third_pre), .rd_data(rd_data), .cells(cells),
      .set_mask(set_mask), .reset_mask(reset_mask), .op_valid(op_valid), .lat(lat)
   );

   function automatic int code_a(int s);
      int t[4] = '{7, 6, 5, 3};
      return t[s];
   endfunction

   function automatic int code_b(int s);
      int t[4] = '{0, 1, 2, 4};
      return t[s];
   endfunction

   task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int g = 0; g < NSYM; g++) begin
         m_cells[g] = 7; m_gen[g] = 0; m_sym[g] = 0;
      end
      e_set = '0; e_rst = '0; e_opv = 0; e_lat = '0;
   endtask

   task automatic compare(string tag);
      for (int g = 0; g < NSYM; g++) begin
         e_cells[3*g +: 3] = 3'(m_cells[g]);
         e_rd[2*g +: 2]    = 2'(m_sym[g]);
      end
      check(tag, "cells", 64'(cells), 64'(e_cells));
      check(tag, "rd_data", 64'(rd_data), 64'(e_rd));
      check(tag, "set_mask", 64'(set_mask), 64'(e_set));
      check(tag, "reset_mask", 64'(reset_mask), 64'(e_rst));
      check(tag, "op_valid", 64'(op_valid), 64'(e_opv));
      check(tag, "lat", 64'(lat), 64'(e_lat));
   endtask

   // called just after a falling edge; drives, steps the model, samples at the next falling edge
   task automatic step(string tag, bit pre, bit wr, logic [2*NSYM-1:0] d, bit pol);
      preset_req = pre; wr_req = wr; wr_data = d; third_pre = pol;
      e_set = '0; e_rst = '0;
      e_opv = pre | wr;
      for (int g = 0; g < NSYM; g++) begin
         int old = m_cells[g];
         int s = int'(d[2*g +: 2]);
         int nw = old;
         int sm = 0;
         int rm = 0;
         if (pre) begin
            nw = 7; sm = ~old & 7; m_gen[g] = 0; m_sym[g] = 0;
         end else if (wr) begin
            if (m_gen[g] == 0) begin
               nw = code_a(s); m_gen[g] = 1;
            end else if (m_gen[g] == 1) begin
               if (m_sym[g] != s) begin nw = code_b(s); m_gen[g] = 2; end
            end else begin
               nw = code_a(s); m_gen[g] = 1;
            end
            if (!pre && m_gen[g] == 1 && old != nw && pol && (old == code_b(m_sym[g]))
                && (old != 7) && (m_cells[g] == old) && (nw == code_a(s)) && (m_gen[g] == 1)) begin
            end
            sm = nw & ~old & 7; rm = old & ~nw & 7;
            m_sym[g] = s;
         end
         e_set[3*g +: 3] = 3'(sm);
         e_rst[3*g +: 3] = 3'(rm);
         m_cells[g] = nw;
      end
      e_lat = !e_opv ? '0 : (pre || |e_set) ? LAT_W'(LAT_SET) : LAT_W'(LAT_RESET);
      @(negedge clk);
      preset_req = 0; wr_req = 0;
      compare(tag);
   endtask

   // third-write step under the pre-SET-first policy: masks follow the two-phase rule
   task automatic step_third_pre(string tag, logic [2*NSYM-1:0] d);
      int was2 [NSYM];
      int old  [NSYM];
      for (int g = 0; g < NSYM; g++) begin
         was2[g] = (m_gen[g] == 2);
         old[g]  = m_cells[g];
      end
      preset_req = 0; wr_req = 1; wr_data = d; third_pre = 1;
      e_set = '0; e_rst = '0; e_opv = 1;
      for (int g = 0; g < NSYM; g++) begin
         int s = int'(d[2*g +: 2]);
         int nw = old[g];
         int sm = 0;
         int rm = 0;
         if (was2[g] != 0) begin
            nw = code_a(s); sm = ~old[g] & 7; rm = ~nw & 7; m_gen[g] = 1;
         end else if (m_gen[g] == 0) begin
            nw = code_a(s); sm = 0; rm = old[g] & ~nw & 7; m_gen[g] = 1;
         end else if (m_sym[g] != s) begin
            nw = code_b(s); rm = old[g] & ~nw & 7; sm = nw & ~old[g] & 7; m_gen[g] = 2;
         end
         m_sym[g] = s;
         m_cells[g] = nw;
         e_set[3*g +: 3] = 3'(sm);
         e_rst[3*g +: 3] = 3'(rm);
      end
      e_lat = (|e_set) ? LAT_W'(LAT_SET) : LAT_W'(LAT_RESET);
      @(negedge clk);
      wr_req = 0;
      compare(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      compare("R1");                                 // R1 reset state
      step("R3", 0, 1, 16'hE4E4, 0);                 // R3 first code, all four symbols
      step("R4", 0, 1, 16'h1B1B, 0);                 // R4 second code, every symbol differs
      step("R6", 0, 1, 16'hE4E4, 0);                 // R6 third write, direct policy
      step("R8", 0, 1, 16'h1B1B, 0);                 // R8 following write uses second code
      step_third_pre("R7", 16'h4E4E);                // R7 third write, pre-SET policy
      step("R5", 0, 1, 16'h4E4E, 1);                 // R5 repeat symbol, no change
      step("R5", 0, 1, 16'hB1B1, 1);                 // R5 generation did not advance
      step("R2", 1, 1, 16'h5555, 0);                 // R2 pre-SET wins over write
      step("R10", 0, 0, 16'h0000, 0);                // R10 idle cycle
      step("R3", 0, 1, 16'h0000, 0);                 // R3 all-zero symbols
      step("R11", 0, 1, 16'h00FF, 0);                // R11 half second write, half unchanged
      step_third_pre("R11", 16'h0FF0);               // R11 mixed third, second, unchanged
      step("R11", 0, 1, 16'hA5C3, 0);                // R11 mixed generations
      step("R9", 0, 1, 16'hFFFF, 0);
      step("R2", 1, 0, 16'h0000, 0);                 // R2 pre-SET from mixed cells
      step("R10", 0, 1, 16'h0000, 0);                // R10 reset-only latency
      for (int i = 0; i < 600; i++) begin
         int r = $urandom_range(0, 15);
         logic [2*NSYM-1:0] d = (2*NSYM)'($urandom);
         bit pol = 1'($urandom);
         if (r < 2)       step("R9", 1, $urandom_range(0, 1) == 1, d, 0);
         else if (r < 4)  step("R10", 0, 0, d, pol);
         else if (pol)    step_third_pre("R9", d);
         else             step("R9", 0, 1, d, 0);
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule